// File: doc/BRIEF.md
# Sinusoidal Current Load Sequencer

This block switches a bank of identical constant-current load cells on and off so that the number of cells drawing current follows a sampled cosine. The summed supply current is then a sinusoid whose frequency is set by a tuning word. A phase accumulator inside the block advances by the active tuning word on every enabled clock. Its top bits index a computed cosine table of load counts, and each count is expanded into a thermometer vector that fills from bit 0 upward.

With the enable low, every cell is off, which gives the quiescent baseline for a supply measurement. A tuning word of zero holds the bank at half load, which gives the zero-frequency measurement point. As the tuning word approaches half the accumulator range, the waveform gets coarser. At exactly half the range it becomes a full-swing square wave at half the clock rate.

A one-clock trigger marks every accumulator wrap, and the top accumulator bits are exported as a phase reference for a downstream magnitude and phase detector. A new tuning word takes effect only at a wrap, so the shape of a period in progress never changes.

Top module: `load_sine_seq`

## Requirements
- R1: While reset is asserted, load_en, trigger and ref_phase are all zero.
- R2: On a clock edge with enable low, load_en, trigger and ref_phase become zero and the accumulator is cleared. The next enabled edge advances from phase zero, using the tuning word that was present at the last disabled edge.
- R3: load_en is always a thermometer code. With a count of c, bits 0 to c-1 are one and all higher bits are zero.
- R4: On each enabled edge with a nonzero active word w, the accumulator becomes (acc + w) mod 2^ACC_W. The count then becomes round(LOADS/2 * (1 + cos(2*pi*p/2^IDX_W))), where p is the top IDX_W bits of the new accumulator.
- R5: trigger is high for exactly the cycle after an enabled edge whose addition carries out of the accumulator, and is low otherwise.
- R6: ref_phase equals the top IDX_W bits of the accumulator after the most recent edge.
- R7: The active word is replaced by tune_word only on a wrapping edge, on a disabled edge, or when the active word is zero. A change to tune_word at any other time has no effect on the phase step until the next wrap.
- R8: When the active word is zero, the accumulator holds its value and the count is LOADS/2 (rounded down), so load_en is half-filled.
- R9: With a tuning word of 2^(ACC_W-1) started from phase zero, load_en alternates between all zeros and all ones on consecutive cycles. The trigger is high on the all-ones cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the waveform; low forces all loads off |
| tune_word | input | ACC_W | Phase increment per clock |
| load_en | output | LOADS | Thermometer-coded load cell enables |
| trigger | output | 1 | One-clock pulse on accumulator wrap |
| ref_phase | output | IDX_W | Top accumulator bits as phase reference |

## Verification
The bench builds the block with its defaults: 16 load cells, a 32-bit accumulator and a 256-entry cosine table. With these values a tuning word of 2^24 gives exactly 256 clocks per period, so the wrap count over a fixed window can be checked exactly. 2^31 reaches the half-clock square wave, and a word of 0xF0000000 reaches wraps on nearly every cycle. Sixteen cells make the half-load value 0x00FF and the full-swing value 0xFFFF, so both are easy to recognize. The word is also changed mid-period to show that the step holds until the next wrap.

// File: rtl/load_sine_seq.sv
module load_sine_seq #(
  parameter int LOADS = 16,
  parameter int ACC_W = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [ACC_W-1:0] tune_word,
  output logic [LOADS-1:0] load_en,
  output logic             trigger,
  output logic [IDX_W-1:0] ref_phase
);

  localparam int CW    = $clog2(LOADS + 1);
  localparam int DEPTH = 1 << IDX_W;
  localparam int MID   = LOADS / 2;

  function automatic int cos_level(input int i);
    real ang;
    ang = 2.0 * 3.14159265358979 * i / DEPTH;
    return $rtoi(LOADS / 2.0 * (1.0 + $cos(ang)) + 0.5);
  endfunction

  logic [ACC_W-1:0] acc, tw_act;
  logic [ACC_W:0]   sum;
  logic [IDX_W-1:0] idx_nx;
  logic [CW-1:0]    count_nx;
  logic [CW-1:0]    tab [DEPTH];
  logic [LOADS-1:0] therm_nx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_tab
    localparam int LV = cos_level(i);
    assign tab[i] = CW'(LV);
  end

  assign sum      = {1'b0, acc} + {1'b0, tw_act};
  assign idx_nx   = sum[ACC_W-1 -: IDX_W];
  assign count_nx = (tw_act == '0) ? CW'(MID) : tab[idx_nx];

  for (genvar k = 0; k < LOADS; k++) begin : g_therm
    assign therm_nx[k] = (count_nx > CW'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      tw_act    <= '0;
      load_en   <= '0;
      trigger   <= 1'b0;
      ref_phase <= '0;
    end else if (!enable) begin
      acc       <= '0;
      tw_act    <= tune_word;
      load_en   <= '0;
      trigger   <= 1'b0;
      ref_phase <= '0;
    end else begin
      acc <= sum[ACC_W-1:0];
      if (sum[ACC_W] || tw_act == '0)
        tw_act <= tune_word;
      load_en   <= therm_nx;
      trigger   <= sum[ACC_W];
      ref_phase <= idx_nx;
    end
  end

endmodule

// File: rtl/load_sine_seq_chk.sv
module load_sine_seq_chk #(
  parameter int LOADS = 16,
  parameter int ACC_W = 32,
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [ACC_W-1:0] tune_word,
  input logic [LOADS-1:0] load_en,
  input logic             trigger,
  input logic [IDX_W-1:0] ref_phase
);

  logic [LOADS:0] bump;
  assign bump = {1'b0, load_en} + 1'b1;

  assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (load_en == '0 && !trigger))
    else $error("disabled sequencer left loads or trigger active");

  assert_idle_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> ref_phase == '0)
    else $error("phase reference not cleared while disabled");

  assert_thermo_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bump[LOADS-1:0] & load_en) == '0)
    else $error("load enables are not a thermometer code");

  assert_trig_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !trigger)
    else $error("trigger after a disabled edge");

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (load_en == '0 && !trigger && ref_phase == '0)
        else $error("outputs active during reset");
    end
  end

endmodule

bind load_sine_seq load_sine_seq_chk #(.LOADS(LOADS), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .tune_word(tune_word),
  .load_en(load_en), .trigger(trigger), .ref_phase(ref_phase)
);

// File: tb/load_sine_seq_test.sv
module load_sine_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int LOADS = 16;
  localparam int ACC_W = 32;
  localparam int IDX_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [ACC_W-1:0] tune_word = '0;
  logic [LOADS-1:0] load_en;
  logic trigger;
  logic [IDX_W-1:0] ref_phase;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;

  load_sine_seq uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tune_word(tune_word),
    .load_en(load_en), .trigger(trigger), .ref_phase(ref_phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  longint m_acc = 0, m_tw = 0;
  longint m_load = 0, m_ph = 0;
  bit m_trig = 0;

  function automatic int lvl(input longint p);
    real ang;
    ang = 2.0 * 3.14159265358979 * p / 256.0;
    return $rtoi(LOADS / 2.0 * (1.0 + $cos(ang)) + 0.5);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_tw = 0; m_load = 0; m_trig = 0; m_ph = 0;
    end else if (!enable) begin
      m_acc = 0; m_tw = longint'(tune_word); m_load = 0; m_trig = 0; m_ph = 0;
    end else begin
      longint s;
      longint used;
      int c;
      used = m_tw;
      s = m_acc + used;
      m_trig = (s >= 64'h1_0000_0000);
      m_acc = s & 64'hFFFF_FFFF;
      if (m_trig || used == 0) m_tw = longint'(tune_word);
      m_ph = m_acc >> 24;
      c = (used == 0) ? LOADS / 2 : lvl(m_ph);
      m_load = (64'd1 << c) - 1;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk({cur_req, " load_en"}, longint'(load_en), m_load);
      chk({cur_req, " trigger R5"}, longint'(trigger), longint'(m_trig));
      chk({cur_req, " ref_phase R6"}, longint'(ref_phase), m_ph);
    end
  end

  int trig_cnt = 0;
  always @(posedge clk) if (cmp_on && trigger) trig_cnt++;

  initial begin
    #(CLK_PERIOD * 60000);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [IDX_W-1:0] ph0;
    repeat (3) @(negedge clk);
    chk("R1 load_en", longint'(load_en), 0);
    chk("R1 trigger", longint'(trigger), 0);
    chk("R1 ref_phase", longint'(ref_phase), 0);

    rst_n = 1'b1;
    tune_word = 32'h0100_0000;
    cmp_on = 1'b1;
    cur_req = "R2";
    repeat (4) @(negedge clk);
    chk("R2 idle load_en", longint'(load_en), 0);

    cur_req = "R4";
    trig_cnt = 0;
    enable = 1'b1;
    @(negedge clk);
    chk("R2 restart phase", longint'(ref_phase), 1);
    repeat (599) @(negedge clk);
    chk("R5 wraps in 600 cycles", trig_cnt, 2);

    cur_req = "R7";
    ph0 = ref_phase;
    tune_word = 32'h0400_0000;
    @(negedge clk);
    chk("R7 step held", longint'(ref_phase), longint'(ph0) + 1);
    @(negedge clk);
    chk("R7 step held again", longint'(ref_phase), longint'(ph0) + 2);
    repeat (300) @(negedge clk);

    cur_req = "R8";
    enable = 1'b0;
    tune_word = '0;
    @(negedge clk);
    enable = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 half load", longint'(load_en), 64'h00FF);
    chk("R8 phase held", longint'(ref_phase), 0);
    tune_word = 32'h0200_0000;
    repeat (200) @(negedge clk);

    cur_req = "R9";
    enable = 1'b0;
    tune_word = 32'h8000_0000;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk("R9 low half", longint'(load_en), 0);
    @(negedge clk);
    chk("R9 high half", longint'(load_en), 64'hFFFF);
    chk("R9 trigger on high", longint'(trigger), 1);
    @(negedge clk);
    chk("R9 low again", longint'(load_en), 0);
    repeat (20) @(negedge clk);

    cur_req = "R3";
    enable = 1'b0;
    tune_word = 32'h2345_6789;
    @(negedge clk);
    enable = 1'b1;
    repeat (400) @(negedge clk);
    chk("R3 thermometer", longint'(((load_en + 1'b1) & load_en) == '0), 1);

    cur_req = "R4";
    tune_word = 32'hF000_0000;
    repeat (300) @(negedge clk);

    cur_req = "R2";
    enable = 1'b0;
    @(negedge clk);
    chk("R2 disabled load_en", longint'(load_en), 0);
    chk("R2 disabled trigger", longint'(trigger), 0);
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule